// File: doc/BRIEF.md
# Flash thermometer-to-binary encoder

This block converts the raw comparator bank of a 3-bit flash converter into a binary sample code. The comparator outputs arrive as a 7-bit thermometer word. Bit 0 carries the lowest threshold level, and a clean word has its lowest k bits set for level k. The word first passes through a Gray encoder in which every thermometer bit drives exactly one Gray bit. The Gray word is then registered, so that a comparator caught between states has a full clock to resolve.

In the second stage the registered Gray word is turned into binary and registered again. A sample marked by `valid_i` therefore shows up on `bin_o` two clocks later, and `valid_o` is raised in the same cycle. Between valid samples both pipeline stages keep their contents.

The resolution is a parameter (`BITS`, default 3). The thermometer width is `2**BITS - 1`.

Top module: `flash_therm_enc`

## Requirements
- R1: While `rst_ni` is low, `bin_o` is 0 and `valid_o` is 0, whatever `therm_i` and `valid_i` carry.
- R2: `valid_o` is the value `valid_i` had two rising clock edges earlier. It is 0 for the first two edges after reset is released.
- R3: A clean thermometer word whose lowest k bits are set (bit 0 is the lowest level, k = 0..7) gives `bin_o` = k two edges after it is sampled with `valid_i` high.
- R4: For any input word, Gray bit g of the sampled word is defined as follows. Take every pair of levels (L, L + 2^(g+1)), where L = 2^g + j·2^(g+2). Gray bit g is the OR over these pairs of (level L set AND level L + 2^(g+1) clear). A level above 7 counts as clear. Two edges after sampling, `bin_o` equals that Gray word converted to binary: the top binary bit is the top Gray bit, and each lower binary bit is the next higher binary bit XOR its Gray bit.
- R5: Two input words that differ in one bit produce outputs whose Gray forms (`b ^ (b >> 1)`) differ in at most one bit.
- R6: Take a clean word of level k (k = 0..6) and let the boundary comparator, bit index k, resolve either way. The output is k or k+1.
- R7: Take a sparkle word for k = 2..7: levels 1..k set except level k-1, which is bit index k-2. The output lies within one code of k or within one code of k-2.
- R8: A sample taken with `valid_i` low loads neither stage. `bin_o` keeps the code of the last valid sample while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| therm_i | input | 2**BITS-1 | Comparator outputs, bit 0 = lowest level |
| valid_i | input | 1 | Marks a sample to convert |
| bin_o | output | BITS | Binary code of the sample from two clocks earlier |
| valid_o | output | 1 | `valid_i` delayed by two clocks |

## Verification
Two things can happen in the same cycle. The binary stage can be converting one sample while the Gray stage captures the next. The binary stage can also be holding its value while a new valid sample enters behind a gap. The bench provokes both by streaming all 128 input words back to back, and then by streams in which `valid_i` is toggled so that loads and holds alternate between the stages. A behavioural queue of sampled inputs predicts `valid_o` and the held `bin_o` on every clock. The queue also covers the corrupted-word cases: each word is given single-bit flips, sparkles and boundary bits resolved both ways.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  localparam int unsigned DEF_BITS = 3;

  function automatic int unsigned level_count(input int unsigned bits);
    return (1 << bits) - 1;
  endfunction
endpackage

// File: rtl/therm_to_gray.sv
module therm_to_gray
  import flash_enc_pkg::*;
#(
  parameter int unsigned BITS = DEF_BITS,
  localparam int unsigned N = level_count(BITS)
) (
  input  logic [N-1:0]    therm_i,
  output logic [BITS-1:0] gray_o
);
  // each level bit lands in exactly one gray bit
  for (genvar k = 0; k < BITS; k++) begin : g_bit
    localparam int NJ = (N >> (k + 2)) + 1;
    logic [NJ-1:0] term;
    for (genvar j = 0; j < NJ; j++) begin : g_term
      localparam int LO = (1 << k) + j * (1 << (k + 2));
      localparam int HI = LO + (1 << (k + 1));
      if (HI <= N) begin : g_pair
        assign term[j] = therm_i[LO-1] & ~therm_i[HI-1];
      end else begin : g_edge
        assign term[j] = therm_i[LO-1];
      end
    end
    assign gray_o[k] = |term;
  end
endmodule

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int unsigned BITS = flash_enc_pkg::DEF_BITS
) (
  input  logic [BITS-1:0] gray_i,
  output logic [BITS-1:0] bin_o
);
  assign bin_o[BITS-1] = gray_i[BITS-1];
  for (genvar k = 0; k < BITS - 1; k++) begin : g_xor
    assign bin_o[k] = bin_o[k+1] ^ gray_i[k];
  end
endmodule

// File: rtl/enc_stage.sv
module enc_stage #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         v_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
      v_o <= 1'b0;
    end else begin
      v_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import flash_enc_pkg::*;
#(
  parameter int unsigned BITS = DEF_BITS,
  localparam int unsigned N = level_count(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    therm_i,
  input  logic            valid_i,
  output logic [BITS-1:0] bin_o,
  output logic            valid_o
);
  logic [BITS-1:0] gray_d, gray_q, bin_d;
  logic            gray_v;

  therm_to_gray #(.BITS(BITS)) u_t2g (.therm_i(therm_i), .gray_o(gray_d));

  // gray register: settling time for unresolved comparators
  enc_stage #(.W(BITS)) u_gray_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i),
    .d_i(gray_d), .q_o(gray_q), .v_o(gray_v)
  );

  gray_to_bin #(.BITS(BITS)) u_g2b (.gray_i(gray_q), .bin_o(bin_d));

  enc_stage #(.W(BITS)) u_bin_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(gray_v),
    .d_i(bin_d), .q_o(bin_o), .v_o(valid_o)
  );
endmodule

// File: rtl/flash_enc_chk.sv
module flash_enc_chk
  import flash_enc_pkg::*;
#(
  parameter int unsigned BITS = DEF_BITS,
  localparam int unsigned N = level_count(BITS),
  localparam int unsigned TOP = (1 << (BITS - 1)) - 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    therm_i,
  input logic            valid_i,
  input logic [BITS-1:0] gray_q_i,
  input logic            gray_v_i,
  input logic [BITS-1:0] bin_i,
  input logic            valid_o_i
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic clean;
  assign clean = ((therm_i & (therm_i + 1'b1)) == '0);

  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (bin_i == '0) && !valid_o_i);

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (valid_o_i == $past(valid_i, 2)));

  // R3
  clean_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && $past(valid_i, 2) && $past(clean, 2)
      |-> (32'(bin_i) == 32'($countones($past(therm_i, 2)))));

  // R4
  gray_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1) && $past(valid_i) |-> (gray_q_i[BITS-1] == $past(therm_i[TOP])));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gray_v_i |=> $stable(bin_i));
endmodule

bind flash_therm_enc flash_enc_chk #(.BITS(BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .therm_i(therm_i), .valid_i(valid_i),
  .gray_q_i(gray_q), .gray_v_i(gray_v), .bin_i(bin_o), .valid_o_i(valid_o)
);

// File: tb/sim_flash_therm_enc.sv
module sim_flash_therm_enc;
  localparam int BITS = 3;
  localparam int N = (1 << BITS) - 1;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [N-1:0]    therm_i;
  logic            valid_i;
  logic [BITS-1:0] bin_o;
  logic            valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int exp_hold = 0;
  logic [N:0] hist[$];

  always #10 clk = ~clk;

  flash_therm_enc #(.BITS(BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .therm_i(therm_i), .valid_i(valid_i),
    .bin_o(bin_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // behavioural spec of R4
  function automatic int ref_code(input logic [N-1:0] t);
    int acc = 0;
    int b = 0;
    for (int k = BITS - 1; k >= 0; k--) begin
      int g = 0;
      for (int lo = (1 << k); lo <= N; lo += (1 << (k + 2))) begin
        int hi = lo + (1 << (k + 1));
        if (t[lo-1] && (hi > N || !t[hi-1])) g = 1;
      end
      acc ^= g;
      b |= acc << k;
    end
    return b;
  endfunction

  function automatic int gray_of(input int b);
    return b ^ (b >> 1);
  endfunction

  // drive at negedge, compare model at next negedge
  task automatic step(input logic [N-1:0] t, input logic v);
    therm_i = t;
    valid_i = v;
    @(posedge clk);
    hist.push_back({v, t});
    @(negedge clk);
    if (hist.size() >= 2) begin
      logic [N:0] e;
      e = hist[hist.size()-2];
      if (e[N]) exp_hold = ref_code(e[N-1:0]);
      chk("R2 valid_o", int'(valid_o), int'(e[N]));
    end else begin
      chk("R2 valid_o", int'(valid_o), 0);
    end
    chk("R4 bin_o", int'(bin_o), exp_hold);
  endtask

  task automatic conv(input logic [N-1:0] t, output int code);
    step(t, 1'b1);
    step(t, 1'b0);
    code = int'(bin_o);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, c2;
    rst_ni = 1'b1;
    therm_i = '1;
    valid_i = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 bin_o", int'(bin_o), 0);
    chk("R1 valid_o", int'(valid_o), 0);
    valid_i = 1'b0;
    therm_i = '0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 latency around a single valid sample
    step('0, 1'b0);
    step(7'b0000111, 1'b1);
    chk("R2 one edge", int'(valid_o), 0);
    step('0, 1'b0);
    chk("R2 two edges", int'(valid_o), 1);
    chk("R3 level 3", int'(bin_o), 3);
    step('0, 1'b0);
    chk("R2 drop", int'(valid_o), 0);

    // R3 all clean levels
    for (int k = 0; k <= N; k++) begin
      conv(N'((1 << k) - 1), c);
      chk($sformatf("R3 level %0d", k), c, k);
    end

    // R4 all words back to back, then gapped
    for (int x = 0; x < (1 << N); x++) step(N'(x), 1'b1);
    for (int x = 0; x < (1 << N); x++) step(N'(x * 37), 1'(x % 3 != 1));

    // R8 hold across invalid samples
    conv(7'b0011111, c);
    step(7'b1111111, 1'b0);
    step(7'b0000001, 1'b0);
    chk("R8 held code", int'(bin_o), 5);
    chk("R8 valid low", int'(valid_o), 0);

    // R5 single bit flips
    for (int x = 0; x < (1 << N); x++) begin
      conv(N'(x), c);
      for (int i = 0; i < N; i++) begin
        conv(N'(x ^ (1 << i)), c2);
        total++;
        if ($countones(gray_of(c) ^ gray_of(c2)) > 1) begin
          bad++;
          $display("FAIL R5 x=%0d bit=%0d act=%0d exp_near=%0d", x, i, c2, c);
        end
      end
    end

    // R6 boundary comparator resolving either way, back to back
    for (int k = 0; k < N; k++) begin
      step(N'((1 << k) - 1), 1'b1);
      step(N'((1 << (k + 1)) - 1), 1'b1);
      c = int'(bin_o);
      step('0, 1'b0);
      c2 = int'(bin_o);
      chk($sformatf("R6 low k=%0d", k), c, k);
      chk($sformatf("R6 high k=%0d", k), c2, k + 1);
    end

    // R7 sparkle below the top level
    for (int k = 2; k <= N; k++) begin
      int d1, d2;
      conv(N'(((1 << k) - 1) & ~(1 << (k - 2))), c);
      d1 = (c > k) ? c - k : k - c;
      d2 = (c > k - 2) ? c - (k - 2) : (k - 2) - c;
      total++;
      if (d1 > 1 && d2 > 1) begin
        bad++;
        $display("FAIL R7 k=%0d act=%0d exp=%0d_or_%0d", k, c, k, k - 2);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule